// File: doc/BRIEF.md
# SDRAM Read Path Sequencer

This block carries a single read from a user-side request port to a PHY-facing command port and back. A request is a flat local address plus a beat count. The block splits the address into row, bank and column. In half-rate operation the column field is moved up by two bit positions. The block then raises a one-cycle read command toward the PHY with those three addresses.

A fixed number of cycles after the command, which models the memory read latency, the block raises a capture-window strobe. The strobe stays high for one controller cycle per expected data beat, so the PHY knows how long to keep its capture registers enabled.

Beats that the PHY returns come back to the user through a return stage with a fixed delay. The delay is zero cycles when ECC is off, and one or three cycles when an ECC stage is present. Data and valid always move together through that stage. The block takes no new request until the user has seen every beat of the current one.

The request side is valid/ready. A request is taken on a rising edge where both valid and ready are high. Ready is low for the whole time a read is outstanding, and the requester must hold its request until it is taken. The return side has no back-pressure: the PHY cannot be stalled, so the user must accept each beat in the cycle its valid flag is high.

Top module: `rd_seq_top`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no read is outstanding, and `busy` is always its inverse.
- R2: The local address is split from its most significant bit down: bits [25:13] form the row, bits [12:10] form the bank and bits [9:0] form the local column. The memory column equals the local column multiplied by 4 (12 bits). For example, address 0x000001 gives row 0x0000, bank 0x0 and column 0x0004.
- R3: In the cycle after acceptance, `phy_cmd_rd` is high for exactly one cycle while the captured row, bank and column appear on the PHY address ports. These addresses stay stable until the read completes.
- R4: If the command is high in cycle t, the first strobe cycle on `phy_rd_win` is cycle t+RD_LAT (default RD_LAT = 4).
- R5: `phy_rd_win` stays high for exactly `req_size` consecutive cycles. `req_size` must be between 1 and 7.
- R6: With ECC_LAT = 0, `lcl_rvalid` and `lcl_rdata` equal `phy_rvalid` and `phy_rdata` in the same cycle.
- R7: With ECC_LAT of 1 or 3, `lcl_rvalid` and `lcl_rdata` equal the PHY values from exactly ECC_LAT cycles earlier. Beat order is preserved.
- R8: `busy` stays high until `req_size` beats have appeared on `lcl_rvalid`. `req_ready` returns high in the cycle after the last beat.
- R9: While `rst_n` is low at a rising edge, the next cycle shows `phy_cmd_rd`, `phy_rd_win`, `lcl_rvalid` and `busy` all low and `req_ready` high. Any beats held in the return stage are discarded.
- R10: A request presented while a read is outstanding is ignored: it produces no further read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 26 | Local word address |
| req_size | input | 3 | Beats in the burst, 1 to 7 |
| busy | output | 1 | A read is outstanding |
| phy_cmd_rd | output | 1 | Read command strobe to PHY |
| phy_row | output | 13 | Row address to PHY |
| phy_bank | output | 3 | Bank address to PHY |
| phy_col | output | 12 | Column address to PHY |
| phy_rd_win | output | 1 | Capture-window strobe, one cycle per beat |
| phy_rdata | input | 16 | Read data from PHY |
| phy_rvalid | input | 1 | Read data valid from PHY |
| lcl_rdata | output | 16 | Read data to user |
| lcl_rvalid | output | 1 | Read data valid to user |

## Verification
Faults in the sequencer state show up within one read.

- A wrong wait count moves the first strobe cycle away from command-plus-latency.
- A wrong window count changes how many beats the PHY model sends back.
- A wrong return count shifts the cycle in which ready comes back, relative to the last local beat.

A return stage with the wrong depth misaligns `lcl_rvalid` against the PHY's valid history in the first beat of every burst. A bad field split shows up at the address ports in the command cycle itself.

// File: rtl/rd_seq_pkg.sv
package rd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_WIN,
    ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/rd_addr_map.sv
module rd_addr_map #(
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 10,
  parameter int COL_SHIFT = 2,
  localparam int ADDR_W   = ROW_W + BANK_W + COL_W,
  localparam int MCOL_W   = COL_W + COL_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank,
  output logic [MCOL_W-1:0] col
);
  logic [COL_W-1:0] lcol;

  // Split from the top: row, then bank, then column.
  assign row  = addr[ADDR_W-1 -: ROW_W];
  assign bank = addr[COL_W +: BANK_W];
  assign lcol = addr[COL_W-1:0];

  generate
    if (COL_SHIFT == 0) begin : g_full_rate
      assign col = lcol;
    end else begin : g_half_rate
      assign col = {lcol, {COL_SHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/rd_ret_pipe.sv
module rd_ret_pipe #(
  parameter int DATA_W = 16,
  parameter int LAT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  generate
    if (LAT == 0) begin : g_bypass
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end else begin : g_stages
      logic              v_q [LAT];
      logic [DATA_W-1:0] d_q [LAT];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < LAT; i++) begin
            v_q[i] <= 1'b0;
            d_q[i] <= '0;
          end
        end else begin
          v_q[0] <= in_valid;
          d_q[0] <= in_data;
          for (int i = 1; i < LAT; i++) begin
            v_q[i] <= v_q[i-1];
            d_q[i] <= d_q[i-1];
          end
        end
      end

      assign out_valid = v_q[LAT-1];
      assign out_data  = d_q[LAT-1];

      // Cycles since reset, saturating at LAT, so $past never reaches before reset.
      logic [3:0] since_rst;
      always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst < 4'(LAT)) since_rst <= since_rst + 4'd1;
      end

      assert_lat_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(LAT)) |-> (out_valid == $past(in_valid, LAT)));
      assert_lat_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(LAT) && out_valid) |-> (out_data == $past(in_data, LAT)));
    end
  endgenerate
endmodule

// File: rtl/rd_seq_ctrl.sv
module rd_seq_ctrl
  import rd_seq_pkg::*;
#(
  parameter int SIZE_W  = 3,
  parameter int RD_LAT  = 4,
  localparam int LAT_W  = (RD_LAT < 2) ? 1 : $clog2(RD_LAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SIZE_W-1:0] req_size,
  output logic              req_ready,
  output logic              accept,
  output logic              cmd_rd,
  output logic              rd_win,
  input  logic              beat_in,
  output logic              busy
);
  seq_state_t        state;
  logic [SIZE_W-1:0] size_q;
  logic [LAT_W-1:0]  lat_cnt;
  logic [SIZE_W-1:0] win_cnt;
  logic [SIZE_W-1:0] ret_cnt;
  logic              last_beat;
  logic              all_back;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_rd    = (state == ST_CMD);
  assign rd_win    = (state == ST_WIN);
  assign last_beat = beat_in && (ret_cnt == size_q - SIZE_W'(1));
  assign all_back  = (ret_cnt == size_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_cnt <= '0;
    end else if (state == ST_IDLE) begin
      ret_cnt <= '0;
    end else if (beat_in && !all_back) begin
      ret_cnt <= ret_cnt + SIZE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      size_q  <= '0;
      lat_cnt <= '0;
      win_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            size_q <= req_size;
            state  <= ST_CMD;
          end
        end
        ST_CMD: begin
          lat_cnt <= '0;
          win_cnt <= '0;
          state   <= (RD_LAT < 2) ? ST_WIN : ST_WAIT;
        end
        ST_WAIT: begin
          if (lat_cnt == LAT_W'(RD_LAT - 2)) state <= ST_WIN;
          else lat_cnt <= lat_cnt + LAT_W'(1);
        end
        ST_WIN: begin
          if (win_cnt == size_q - SIZE_W'(1)) state <= ST_DRAIN;
          else win_cnt <= win_cnt + SIZE_W'(1);
        end
        ST_DRAIN: begin
          if (all_back || last_beat) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-side count of strobe cycles in the current window.
  logic [SIZE_W-1:0] chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_len <= '0;
    else if (rd_win) chk_len <= chk_len + SIZE_W'(1);
    else chk_len <= '0;
  end

  assert_cmd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> !cmd_rd);
  assert_cmd_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cmd_rd);
  assert_cmd_needs_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |-> $past(accept));
  assert_win_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_win) |-> (chk_len == size_q));
  assert_no_ready_with_win_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_win |-> !req_ready);
endmodule

// File: rtl/rd_seq_top.sv
module rd_seq_top #(
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 10,
  parameter int COL_SHIFT = 2,
  parameter int SIZE_W    = 3,
  parameter int DATA_W    = 16,
  parameter int RD_LAT    = 4,
  parameter int ECC_LAT   = 1,
  localparam int ADDR_W   = ROW_W + BANK_W + COL_W,
  localparam int MCOL_W   = COL_W + COL_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              busy,
  output logic              phy_cmd_rd,
  output logic [ROW_W-1:0]  phy_row,
  output logic [BANK_W-1:0] phy_bank,
  output logic [MCOL_W-1:0] phy_col,
  output logic              phy_rd_win,
  input  logic [DATA_W-1:0] phy_rdata,
  input  logic              phy_rvalid,
  output logic [DATA_W-1:0] lcl_rdata,
  output logic              lcl_rvalid
);
  logic              accept;
  logic [ROW_W-1:0]  m_row;
  logic [BANK_W-1:0] m_bank;
  logic [MCOL_W-1:0] m_col;

  rd_addr_map #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .COL_SHIFT(COL_SHIFT)
  ) u_map (
    .addr(req_addr), .row(m_row), .bank(m_bank), .col(m_col)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_row  <= '0;
      phy_bank <= '0;
      phy_col  <= '0;
    end else if (accept) begin
      phy_row  <= m_row;
      phy_bank <= m_bank;
      phy_col  <= m_col;
    end
  end

  rd_seq_ctrl #(
    .SIZE_W(SIZE_W), .RD_LAT(RD_LAT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_size(req_size), .req_ready(req_ready),
    .accept(accept), .cmd_rd(phy_cmd_rd), .rd_win(phy_rd_win),
    .beat_in(lcl_rvalid), .busy(busy)
  );

  rd_ret_pipe #(
    .DATA_W(DATA_W), .LAT(ECC_LAT)
  ) u_ret (
    .clk(clk), .rst_n(rst_n),
    .in_valid(phy_rvalid), .in_data(phy_rdata),
    .out_valid(lcl_rvalid), .out_data(lcl_rdata)
  );

  assert_col_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_cmd_rd |-> ((phy_col % MCOL_W'(1 << COL_SHIFT)) == '0));
  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rd_win |-> ($stable(phy_row) && $stable(phy_bank) && $stable(phy_col)));
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!phy_cmd_rd && !phy_rd_win && !lcl_rvalid && req_ready));
endmodule

// File: tb/rd_seq_top_tb.sv
module rd_seq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RD_LAT     = 4;
  localparam int PHY_DLY    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [25:0] req_addr = '0;
  logic [2:0]  req_size = 3'd1;
  logic [15:0] phy_rdata;
  logic        phy_rvalid;

  logic        rdy [3];
  logic        bsy [3];
  logic        lv  [3];
  logic [15:0] ld  [3];
  logic        cmd [3];
  logic        win [3];
  logic [12:0] row [3];
  logic [2:0]  bnk [3];
  logic [11:0] col [3];
  int          lat_of [3];

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_seq_top #(.RD_LAT(RD_LAT), .ECC_LAT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[2]),
    .req_addr(req_addr), .req_size(req_size), .busy(bsy[2]),
    .phy_cmd_rd(cmd[2]), .phy_row(row[2]), .phy_bank(bnk[2]), .phy_col(col[2]),
    .phy_rd_win(win[2]), .phy_rdata(phy_rdata), .phy_rvalid(phy_rvalid),
    .lcl_rdata(ld[2]), .lcl_rvalid(lv[2]));

  rd_seq_top #(.RD_LAT(RD_LAT), .ECC_LAT(1)) u_dut_e1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_addr(req_addr), .req_size(req_size), .busy(bsy[1]),
    .phy_cmd_rd(cmd[1]), .phy_row(row[1]), .phy_bank(bnk[1]), .phy_col(col[1]),
    .phy_rd_win(win[1]), .phy_rdata(phy_rdata), .phy_rvalid(phy_rvalid),
    .lcl_rdata(ld[1]), .lcl_rvalid(lv[1]));

  rd_seq_top #(.RD_LAT(RD_LAT), .ECC_LAT(0)) u_dut_e0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_addr(req_addr), .req_size(req_size), .busy(bsy[0]),
    .phy_cmd_rd(cmd[0]), .phy_row(row[0]), .phy_bank(bnk[0]), .phy_col(col[0]),
    .phy_rd_win(win[0]), .phy_rdata(phy_rdata), .phy_rvalid(phy_rvalid),
    .lcl_rdata(ld[0]), .lcl_rvalid(lv[0]));

  // PHY model: one incrementing beat PHY_DLY cycles after each strobe cycle.
  logic [PHY_DLY-1:0] dline;
  always @(posedge clk) begin
    if (!rst_n) begin
      dline <= '0;
      phy_rvalid <= 1'b0;
      phy_rdata <= 16'h0;
    end else begin
      dline <= {dline[PHY_DLY-2:0], win[2]};
      if (phy_rvalid) phy_rdata <= phy_rdata + 16'd1;
      phy_rvalid <= dline[PHY_DLY-2];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] pick_addr(input int i);
    case (i)
      0: return 26'h000001;
      1: return 26'h3FFFFFF;
      2: return 26'h2AAAAAA;
      3: return 26'h1555555;
      default: return 26'((5 << 13) + (3 << 10) + 17);
    endcase
  endfunction

  task automatic do_read(input logic [25:0] a, input int sz);
    logic        hv [64];
    logic [15:0] hd [64];
    int win_start, win_len, cmd_extra;
    int beats [3];
    int last_c [3];
    int rdy_c [3];
    int mism [3];
    int exp_row, exp_bank, exp_col, c_last;
    exp_row  = int'(a) / 8192;
    exp_bank = (int'(a) / 1024) % 8;
    exp_col  = (int'(a) % 1024) * 4;
    for (int d = 0; d < 3; d++) begin
      beats[d] = 0; last_c[d] = -1; rdy_c[d] = -1; mism[d] = 0;
    end
    win_start = -1; win_len = 0; cmd_extra = 0;

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 3'(sz);
    @(negedge clk);
    // c = 0: command cycle. Keep a junk request up to test R10.
    req_addr = ~a; req_size = 3'd7;
    chk(cmd[2] == 1'b1, "R3 command after accept", int'(cmd[2]), 1);
    chk(row[2] == 13'(exp_row) && bnk[2] == 3'(exp_bank) && col[2] == 12'(exp_col),
        "R2 address split", int'({row[2], bnk[2], col[2]}),
        (exp_row << 15) + (exp_bank << 12) + exp_col);
    chk(rdy[0] == 1'b0 && bsy[0] == 1'b1, "R1 ready low while busy",
        int'(rdy[0]), 0);
    for (int c = 0; c < RD_LAT + sz + PHY_DLY + 8; c++) begin
      if (c > 0) @(negedge clk);
      if (c == RD_LAT) req_valid = 1'b0;
      hv[c] = phy_rvalid;
      hd[c] = phy_rdata;
      if (c > 0 && cmd[2]) cmd_extra++;
      if (win[2]) begin
        if (win_start < 0) win_start = c;
        win_len++;
      end
      for (int d = 0; d < 3; d++) begin
        logic ev;
        logic [15:0] ed;
        ev = (c >= lat_of[d]) ? hv[c - lat_of[d]] : 1'b0;
        ed = (c >= lat_of[d]) ? hd[c - lat_of[d]] : 16'h0;
        if (lv[d] != ev || (ev && ld[d] != ed)) mism[d]++;
        if (lv[d]) begin beats[d]++; last_c[d] = c; end
        if (c > 0 && rdy[d] && rdy_c[d] < 0) rdy_c[d] = c;
      end
    end
    chk(cmd_extra == 0, "R10 request ignored while busy", cmd_extra, 0);
    chk(win_start == RD_LAT, "R4 strobe start", win_start, RD_LAT);
    chk(win_len == sz, "R5 strobe length", win_len, sz);
    for (int d = 0; d < 3; d++) begin
      c_last = RD_LAT + sz - 1 + PHY_DLY + lat_of[d];
      chk(mism[d] == 0, (lat_of[d] == 0) ? "R6 zero-delay return" : "R7 delayed return",
          mism[d], 0);
      chk(beats[d] == sz && last_c[d] == c_last, "R8 beat count and last beat cycle",
          beats[d] * 100 + last_c[d], sz * 100 + c_last);
      chk(rdy_c[d] == c_last + 1, "R8 ready after last beat", rdy_c[d], c_last + 1);
    end
  endtask

  task automatic reset_mid_burst();
    @(negedge clk);
    req_valid = 1'b1; req_addr = pick_addr(4); req_size = 3'd7;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (RD_LAT + PHY_DLY + 2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk(!cmd[d] && !win[d] && !lv[d] && !bsy[d] && rdy[d], "R9 reset mid-burst",
          int'({cmd[d], win[d], lv[d], bsy[d], rdy[d]}), 1);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int d = 0; d < 3; d++)
      chk(!lv[d] && rdy[d], "R9 pipe flushed after reset", int'({lv[d], rdy[d]}), 1);
  endtask

  initial begin
    lat_of[0] = 0; lat_of[1] = 1; lat_of[2] = 3;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++)
      chk(!cmd[d] && !win[d] && !lv[d] && rdy[d] && !bsy[d], "R9 reset state",
          int'({cmd[d], win[d], lv[d], rdy[d], bsy[d]}), 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++)
      for (int s = 1; s <= 7; s++)
        do_read(pick_addr(i), s);
    reset_mid_burst();
    do_read(26'h000001, 2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule